// File: doc/BRIEF.md
# Bus Snoop Coherency Controller

This block watches bus cycles that other masters drive on the external bus and keeps two on-chip caches, an instruction cache and a data cache, coherent with memory. It holds the tag and line-state store of both caches. For each watched cycle it looks up the line the address selects and decides what must happen to it. Which caches are looked up depends on the cycle direction. An external write is checked against both caches. An external read is checked against the data cache only. A cycle whose snoopable flag is clear is left alone.

The action comes from the state of the matching line and the cycle type. A write that hits a valid line invalidates that line. A read that hits a modified data line makes the controller hold off memory and ask the data cache for the line's contents, and the line is then marked clean. Every other case needs no action. The outcome is reported one cycle later with a done strobe.

The same store is shared with the internal execution-unit port, which installs lines and reads back their state. When a watched cycle and an internal request arrive together, the watched cycle wins and the internal request stalls.

Top module: `snp_coherency_ctrl`

## Requirements
- R1: An address splits into a line offset (low log2(LINE_BYTES) bits, ignored), a set index (the next log2(SETS) bits) and a tag (the remaining high bits). A line matches when its stored tag equals the address tag and its state is not invalid. Line state encoding: 0 invalid, 1 clean, 2 dirty.
- R2: A flagged external write that matches a line invalidates it in every cache that holds it, and the result is 1 (invalidate).
- R3: A flagged external read never looks up or changes the instruction cache. A matching instruction line stays valid and the result is 0 (no action) unless the data cache calls for more.
- R4: A flagged external read that matches a dirty data line gives result 2 (supply). It raises snp_inhibit and dc_push_req with dc_push_set set to the line's set index, and the line becomes clean (state 1).
- R5: A flagged read that matches a clean line, and any flagged cycle that matches no line, gives result 0 and changes no line state.
- R6: For every flagged cycle, snp_done is high for exactly one cycle, at the clock edge after the cycle is presented. snp_inhibit and dc_push_req are high only together with a supply result.
- R7: A cycle with snp_flag low, or with snp_valid low, produces no done, changes no line and does not stall the execution-unit port.
- R8: When a flagged cycle and eu_req arrive together, eu_grant is low and the internal request has no effect. Otherwise eu_grant follows eu_req.
- R9: A granted internal request with eu_wr=1 writes the address tag and eu_wstate into the set of the cache that eu_sel picks (0 instruction, 1 data). With eu_wr=0, the line state comes back on eu_rd_state with eu_rd_valid one edge later, and reads 0 when the tag does not match.
- R10: After reset, every line is invalid and every registered output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| snp_valid | input | 1 | External cycle present |
| snp_write | input | 1 | External cycle is a write |
| snp_flag | input | 1 | External cycle is marked snoopable |
| snp_addr | input | ADDR_W | External cycle address |
| eu_req | input | 1 | Execution-unit request |
| eu_sel | input | 1 | Target cache: 0 instruction, 1 data |
| eu_wr | input | 1 | 1 installs a line, 0 reads its state |
| eu_addr | input | ADDR_W | Execution-unit address |
| eu_wstate | input | 2 | Line state to install |
| eu_grant | output | 1 | Execution-unit request accepted this cycle |
| eu_rd_valid | output | 1 | Read-back state is valid |
| eu_rd_state | output | 2 | Read-back line state |
| snp_done | output | 1 | Snoop result strobe |
| snp_result | output | 2 | 0 no action, 1 invalidate, 2 supply |
| snp_inhibit | output | 1 | Hold off memory; the cache supplies data |
| dc_push_req | output | 1 | Ask the data cache to drive the line |
| dc_push_set | output | log2(SETS) | Set index of the line to drive |

## Verification
The main function is tried with every combination that matters: the data line invalid, clean or dirty, and the instruction line present or absent. Each is crossed with read or write, matching or missing tag, and flagged or unflagged. After each snoop the state of both caches is read back through the execution-unit port. Reads against a present instruction line separate the per-direction cache choice from a both-caches lookup. Dirty versus clean read hits separate supply from no action. Unflagged cycles against dirty lines show that the flag really gates the lookup. Extra patterns use a same-tag address in a neighbouring set and a different byte of the same line to pin down the address split. A simultaneous internal install shows snoop priority.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        LS_INV   = 2'd0,
        LS_CLEAN = 2'd1,
        LS_DIRTY = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_INVAL  = 2'd1,
        RES_SUPPLY = 2'd2
    } snoop_res_e;

    localparam int unsigned NCACHE = 2;
    localparam int unsigned CIDX_I = 0;
    localparam int unsigned CIDX_D = 1;

endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array
    import snp_pkg::*;
#(
    parameter int unsigned SET_W = 4,
    parameter int unsigned TAG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd0_set,
    output logic [TAG_W-1:0]  rd0_tag,
    output line_state_e       rd0_state,
    input  logic [SET_W-1:0]  rd1_set,
    output logic [TAG_W-1:0]  rd1_tag,
    output line_state_e       rd1_state,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  line_state_e       wr_state
);
    localparam int unsigned SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q   [SETS];
    line_state_e      state_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                tag_q[i]   <= '0;
                state_q[i] <= LS_INV;
            end
        end else if (wr_en) begin
            tag_q[wr_set]   <= wr_tag;
            state_q[wr_set] <= wr_state;
        end
    end

    assign rd0_tag   = tag_q[rd0_set];
    assign rd0_state = state_q[rd0_set];
    assign rd1_tag   = tag_q[rd1_set];
    assign rd1_state = state_q[rd1_set];

endmodule

// File: rtl/snp_arbiter.sv
module snp_arbiter (
    input  logic snp_valid,
    input  logic snp_flag,
    input  logic eu_req,
    output logic snoop_go,
    output logic eu_grant
);
    always_comb begin
        snoop_go = snp_valid && snp_flag;
        eu_grant = eu_req && !snoop_go;
    end
endmodule

// File: rtl/snp_decide.sv
module snp_decide
    import snp_pkg::*;
(
    input  logic        is_write,
    input  logic        ic_hit,
    input  logic        dc_hit,
    input  line_state_e dc_state,
    output snoop_res_e  res,
    output logic        ic_inval,
    output logic        dc_inval,
    output logic        dc_clean
);
    always_comb begin
        res      = RES_NONE;
        ic_inval = 1'b0;
        dc_inval = 1'b0;
        dc_clean = 1'b0;
        if (is_write) begin
            ic_inval = ic_hit;
            dc_inval = dc_hit;
            if (ic_hit || dc_hit) begin
                res = RES_INVAL;
            end
        end else if (dc_hit && dc_state == LS_DIRTY) begin
            res      = RES_SUPPLY;
            dc_clean = 1'b1;
        end
    end
endmodule

// File: rtl/snp_coherency_ctrl.sv
module snp_coherency_ctrl
    import snp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SETS       = 16,
    parameter int unsigned LINE_BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snp_valid,
    input  logic                     snp_write,
    input  logic                     snp_flag,
    input  logic [ADDR_W-1:0]        snp_addr,
    input  logic                     eu_req,
    input  logic                     eu_sel,
    input  logic                     eu_wr,
    input  logic [ADDR_W-1:0]        eu_addr,
    input  logic [1:0]               eu_wstate,
    output logic                     eu_grant,
    output logic                     eu_rd_valid,
    output logic [1:0]               eu_rd_state,
    output logic                     snp_done,
    output logic [1:0]               snp_result,
    output logic                     snp_inhibit,
    output logic                     dc_push_req,
    output logic [$clog2(SETS)-1:0]  dc_push_set
);
    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned SET_W = $clog2(SETS);
    localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W;

    typedef struct packed {
        logic              done;
        snoop_res_e        result;
        logic              inhibit;
        logic              push_req;
        logic [SET_W-1:0]  push_set;
        logic              rd_valid;
        line_state_e       rd_state;
    } out_t;

    out_t out_d, out_q;

    logic [SET_W-1:0] s_set, e_set;
    logic [TAG_W-1:0] s_tag, e_tag;
    logic             unused_offsets;

    assign s_set = snp_addr[OFF_W +: SET_W];
    assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
    assign e_set = eu_addr[OFF_W +: SET_W];
    assign e_tag = eu_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{snp_addr[OFF_W-1:0], eu_addr[OFF_W-1:0]};

    logic snoop_go;

    snp_arbiter u_arb (
        .snp_valid (snp_valid),
        .snp_flag  (snp_flag),
        .eu_req    (eu_req),
        .snoop_go  (snoop_go),
        .eu_grant  (eu_grant)
    );

    logic [TAG_W-1:0] rd0_tag [NCACHE];
    logic [TAG_W-1:0] rd1_tag [NCACHE];
    line_state_e      rd0_st  [NCACHE];
    line_state_e      rd1_st  [NCACHE];
    logic             s_hit   [NCACHE];
    logic             e_hit   [NCACHE];
    logic             wr_en_d [NCACHE];
    logic [SET_W-1:0] wr_set_d[NCACHE];
    logic [TAG_W-1:0] wr_tag_d[NCACHE];
    line_state_e      wr_st_d [NCACHE];

    for (genvar g = 0; g < NCACHE; g++) begin : g_cache
        snp_tag_array #(
            .SET_W (SET_W),
            .TAG_W (TAG_W)
        ) u_arr (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd0_set   (s_set),
            .rd0_tag   (rd0_tag[g]),
            .rd0_state (rd0_st[g]),
            .rd1_set   (e_set),
            .rd1_tag   (rd1_tag[g]),
            .rd1_state (rd1_st[g]),
            .wr_en     (wr_en_d[g]),
            .wr_set    (wr_set_d[g]),
            .wr_tag    (wr_tag_d[g]),
            .wr_state  (wr_st_d[g])
        );
        assign s_hit[g] = (rd0_st[g] != LS_INV) && (rd0_tag[g] == s_tag);
        assign e_hit[g] = (rd1_st[g] != LS_INV) && (rd1_tag[g] == e_tag);
    end

    snoop_res_e dec_res;
    logic       ic_inval, dc_inval, dc_clean;

    snp_decide u_dec (
        .is_write (snp_write),
        .ic_hit   (s_hit[CIDX_I]),
        .dc_hit   (s_hit[CIDX_D]),
        .dc_state (rd0_st[CIDX_D]),
        .res      (dec_res),
        .ic_inval (ic_inval),
        .dc_inval (dc_inval),
        .dc_clean (dc_clean)
    );

    always_comb begin
        out_d = '0;
        if (snoop_go) begin
            out_d.done     = 1'b1;
            out_d.result   = dec_res;
            out_d.inhibit  = (dec_res == RES_SUPPLY);
            out_d.push_req = (dec_res == RES_SUPPLY);
            out_d.push_set = (dec_res == RES_SUPPLY) ? s_set : '0;
        end
        if (eu_grant && !eu_wr) begin
            out_d.rd_valid = 1'b1;
            out_d.rd_state = e_hit[eu_sel] ? rd1_st[eu_sel] : LS_INV;
        end

        for (int c = 0; c < NCACHE; c++) begin
            wr_en_d[c]  = 1'b0;
            wr_set_d[c] = '0;
            wr_tag_d[c] = '0;
            wr_st_d[c]  = LS_INV;
            if (snoop_go) begin
                wr_en_d[c]  = (c == CIDX_I) ? ic_inval : (dc_inval || dc_clean);
                wr_set_d[c] = s_set;
                wr_tag_d[c] = s_tag;
                wr_st_d[c]  = (c == CIDX_D && dc_clean) ? LS_CLEAN : LS_INV;
            end else if (eu_grant && eu_wr && (int'(eu_sel) == c)) begin
                wr_en_d[c]  = 1'b1;
                wr_set_d[c] = e_set;
                wr_tag_d[c] = e_tag;
                wr_st_d[c]  = line_state_e'(eu_wstate);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign snp_done    = out_q.done;
    assign snp_result  = out_q.result;
    assign snp_inhibit = out_q.inhibit;
    assign dc_push_req = out_q.push_req;
    assign dc_push_set = out_q.push_set;
    assign eu_rd_valid = out_q.rd_valid;
    assign eu_rd_state = out_q.rd_state;

endmodule

// File: rtl/snp_coherency_ctrl_chk.sv
module snp_coherency_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       snp_valid,
    input logic       snp_write,
    input logic       snp_flag,
    input logic       eu_req,
    input logic       eu_wr,
    input logic       eu_grant,
    input logic       eu_rd_valid,
    input logic       snp_done,
    input logic [1:0] snp_result,
    input logic       snp_inhibit,
    input logic       dc_push_req
);
    a_r8_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_flag) |-> !eu_grant);

    a_r8_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!(snp_valid && snp_flag)) |-> (eu_grant == eu_req));

    a_r6_done_next: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_flag) |=> snp_done);

    a_r7_no_done_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!(snp_valid && snp_flag)) |=> !snp_done);

    a_r3_read_never_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_flag && !snp_write) |=> (snp_result != 2'd1));

    a_r2_write_never_supplies: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_flag && snp_write) |=> (snp_result != 2'd2) && !snp_inhibit);

    a_r6_inhibit_only_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_inhibit || dc_push_req) |-> (snp_done && snp_result == 2'd2 && snp_inhibit && dc_push_req));

    a_r9_read_back: assert property (@(posedge clk) disable iff (!rst_n)
        (eu_grant && !eu_wr) |=> eu_rd_valid);

endmodule

bind snp_coherency_ctrl snp_coherency_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (snp_valid),
    .snp_write   (snp_write),
    .snp_flag    (snp_flag),
    .eu_req      (eu_req),
    .eu_wr       (eu_wr),
    .eu_grant    (eu_grant),
    .eu_rd_valid (eu_rd_valid),
    .snp_done    (snp_done),
    .snp_result  (snp_result),
    .snp_inhibit (snp_inhibit),
    .dc_push_req (dc_push_req)
);

// File: tb/tb_snp_coherency_ctrl.sv
`timescale 1ns/1ps
module tb_snp_coherency_ctrl;
    localparam int ADDR_W = 32;
    localparam int SETS   = 16;
    localparam int SET_W  = 4;
    localparam logic [31:0] A_HIT  = 32'h0000_1230;
    localparam logic [31:0] A_MISS = 32'h0001_1230;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 0, snp_write = 0, snp_flag = 0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic eu_req = 0, eu_sel = 0, eu_wr = 0;
    logic [ADDR_W-1:0] eu_addr = '0;
    logic [1:0] eu_wstate = '0;
    logic eu_grant, eu_rd_valid, snp_done, snp_inhibit, dc_push_req;
    logic [1:0] eu_rd_state, snp_result;
    logic [SET_W-1:0] dc_push_set;

    always #2 clk = ~clk;

    snp_coherency_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_flag(snp_flag), .snp_addr(snp_addr),
        .eu_req(eu_req), .eu_sel(eu_sel), .eu_wr(eu_wr), .eu_addr(eu_addr), .eu_wstate(eu_wstate),
        .eu_grant(eu_grant), .eu_rd_valid(eu_rd_valid), .eu_rd_state(eu_rd_state),
        .snp_done(snp_done), .snp_result(snp_result), .snp_inhibit(snp_inhibit),
        .dc_push_req(dc_push_req), .dc_push_set(dc_push_set)
    );

    int total = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic install(input logic sel, input logic [31:0] addr, input logic [1:0] st);
        @(negedge clk);
        eu_req = 1; eu_wr = 1; eu_sel = sel; eu_addr = addr; eu_wstate = st;
        @(negedge clk);
        eu_req = 0; eu_wr = 0;
    endtask

    task automatic lookup(input logic sel, input logic [31:0] addr, output logic vld, output logic [1:0] st);
        @(negedge clk);
        eu_req = 1; eu_wr = 0; eu_sel = sel; eu_addr = addr;
        @(negedge clk);
        vld = eu_rd_valid; st = eu_rd_state;
        eu_req = 0;
    endtask

    task automatic snoop(input logic wr, input logic fl, input logic [31:0] addr);
        @(negedge clk);
        snp_valid = 1; snp_write = wr; snp_flag = fl; snp_addr = addr;
        @(negedge clk);
        snp_valid = 0; snp_flag = 0; snp_write = 0;
    endtask

    // fields: ds[12:11] is[10:9] wr[8] fl[7] hit[6] res[5:4] ds_after[3:2] is_after[1:0]
    localparam logic [12:0] VEC [12] = '{
        {2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 2'd0},  // R4 dirty read hit
        {2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1, 2'd1},  // R5 clean read hit
        {2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd1},  // R3 read ignores icache
        {2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 2'd1},  // R3 R4 both present
        {2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 2'd0},  // R2 both caches
        {2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 2'd0},  // R2 icache only
        {2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd0, 2'd0},  // R2 dirty dcache
        {2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 2'd1},  // R5 read miss
        {2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd2, 2'd1},  // R5 write miss
        {2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0},  // R5 empty caches
        {2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 2'd1},  // R7 unflagged write
        {2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 2'd1}   // R7 unflagged read
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic vld;
        logic [1:0] st;

        // R10 reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "done", snp_done, 0);
        chk("R10", "inhibit", snp_inhibit, 0);
        chk("R10", "push", dc_push_req, 0);
        chk("R10", "rd_valid", eu_rd_valid, 0);
        lookup(1'b1, A_HIT, vld, st);
        chk("R10", "dcache invalid", st, 0);
        lookup(1'b0, A_HIT, vld, st);
        chk("R10", "icache invalid", st, 0);

        for (int i = 0; i < 12; i++) begin
            logic [12:0] v;
            v = VEC[i];
            do_reset();
            if (v[12:11] != 2'd0) install(1'b1, A_HIT, v[12:11]);
            if (v[10:9]  != 2'd0) install(1'b0, A_HIT, v[10:9]);
            snoop(v[8], v[7], v[6] ? A_HIT : A_MISS);
            chk("R6 R7", "done", snp_done, {31'd0, v[7]});
            if (v[7]) begin
                chk("R2 R3 R4 R5", "result", snp_result, {30'd0, v[5:4]});
                chk("R4 R6", "inhibit", snp_inhibit, {31'd0, v[5:4] == 2'd2});
                if (v[5:4] == 2'd2) chk("R4", "push set", {dc_push_req, dc_push_set}, {27'd0, 1'b1, 4'd3});
            end
            lookup(1'b1, A_HIT, vld, st);
            chk("R9", "rd_valid", vld, 1);
            chk("R2 R4 R5 R7", "dcache state", st, {30'd0, v[3:2]});
            lookup(1'b0, A_HIT, vld, st);
            chk("R2 R3 R7", "icache state", st, {30'd0, v[1:0]});
        end

        // R1 address split: same tag, neighbouring set misses; other byte of same line hits
        do_reset();
        install(1'b1, A_HIT, 2'd2);
        snoop(1'b0, 1'b1, A_HIT + 32'h10);
        chk("R1", "neighbour set result", snp_result, 0);
        snoop(1'b0, 1'b1, A_HIT + 32'h4);
        chk("R1", "same line result", snp_result, 2);
        chk("R1", "push set", dc_push_set, 3);
        lookup(1'b1, A_HIT + 32'h8, vld, st);
        chk("R1", "state after supply", st, 1);

        // R9 tag mismatch reads invalid
        lookup(1'b1, A_MISS, vld, st);
        chk("R9", "mismatch state", st, 0);

        // R8 priority: snoop and install together
        do_reset();
        @(negedge clk);
        snp_valid = 1; snp_flag = 1; snp_write = 0; snp_addr = A_MISS;
        eu_req = 1; eu_wr = 1; eu_sel = 1; eu_addr = A_HIT; eu_wstate = 2'd2;
        #1;
        chk("R8", "grant while snooping", eu_grant, 0);
        @(negedge clk);
        snp_valid = 0; snp_flag = 0; eu_req = 0; eu_wr = 0;
        chk("R6", "done pulse", snp_done, 1);
        @(negedge clk);
        chk("R6", "done one cycle", snp_done, 0);
        lookup(1'b1, A_HIT, vld, st);
        chk("R8", "stalled install had no effect", st, 0);

        // R7 R8 unflagged snoop does not block
        @(negedge clk);
        snp_valid = 1; snp_flag = 0; snp_write = 1; snp_addr = A_HIT;
        eu_req = 1; eu_wr = 1; eu_sel = 1; eu_addr = A_HIT; eu_wstate = 2'd2;
        #1;
        chk("R7 R8", "grant with unflagged", eu_grant, 1);
        @(negedge clk);
        snp_valid = 0; eu_req = 0; eu_wr = 0;
        chk("R7", "no done", snp_done, 0);
        lookup(1'b1, A_HIT, vld, st);
        chk("R7 R9", "install landed", st, 2);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule